// File: doc/BRIEF.md
# Sequential Grouped Interrupt Priority Sorter

This block picks one winner out of 32 interrupt request lines. Each line has its own 4-bit priority and a mask bit. A line is a candidate only when its request is high and its mask bit is clear. The block reports the line number of the strongest candidate. A larger priority value is stronger. When two candidates have the same priority, the lower line number wins.

The block does not compare all lines in one cycle. A small controller steps through the lines in groups of four, one group per clock. Each cycle, a five-way comparator weighs the four new candidates against the running winner that was registered in the previous cycle. Each sort clears that running winner first. After the last group, the block loads the result into the output registers and raises a one-cycle completion pulse. The winner outputs then hold until the next completion pulse.

Requests, masks and priorities must not change while a sort is running. The block relies on this and does not check for it.

Top module: `irq_group_sorter`

## Requirements
- R1: While reset (synchronous, active high) is applied and on the first cycle after it, `sort_done` and `win_valid` are 0 and `win_idx` is 0.
- R2: A line whose `irq_mask` bit is 1 never takes part in a sort. If every requesting line is masked, no sort starts and no `sort_done` pulse appears.
- R3: A sort starts on the first rising edge at which the block is idle and at least one request is active and unmasked. `sort_done` is high for exactly one cycle, and it becomes visible right after the ninth rising edge counted from that starting edge (one start cycle plus eight group cycles).
- R4: At `sort_done`, `win_idx` holds the binary line number of the qualified line with the largest 4-bit priority, and `win_valid` is 1. Line n's priority is `irq_prio[4n+3:4n]`.
- R5: When qualified lines with equal top priority fall in the same group of four (lines 4k to 4k+3), the lowest line number wins.
- R6: When qualified lines with equal top priority fall in different groups, the line from the earlier group (lower number) wins.
- R7: `win_idx` and `win_valid` change only at the edge that raises `sort_done`. Between pulses they hold their value, including while the next sort is running.
- R8: If requests stay active after a sort ends, the next sort starts on the following edge, and the next `sort_done` comes nine cycles after the previous one.
- R9: The running winner starts each sort as empty, and any valid candidate beats it. A single request with priority 0 on line 31 (the last group) is still reported with `win_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | 32 | Request lines, bit n is line n |
| irq_mask | input | 32 | Mask bits, 1 removes line n from sorting |
| irq_prio | input | 128 | Packed priorities, 4 bits per line, line n at [4n+3:4n] |
| win_idx | output | 5 | Line number of the last winner |
| win_valid | output | 1 | Last sort found a qualified line |
| sort_done | output | 1 | One-cycle pulse when a new result is loaded |

## Verification
Each stimulus is applied on a falling edge. The bench stores the expected winner in a queue, together with the exact cycle number at which `sort_done` must appear. That cycle is nine rising edges after the stimulus, and held requests add a second result nine cycles after the first. The monitor looks at the outputs only on falling edges. It flags any pulse that arrives early, arrives late, or was not expected. The bench drops the requests on the same falling edge where the pulse is seen, so the next edge finds the block idle. Masked-only stimulus is followed by a 20-cycle quiet window, during which the bench expects no pulse and unchanged winner outputs.

// File: rtl/irq_sort_pkg.sv
package irq_sort_pkg;

    localparam int NUM_LINES  = 32;
    localparam int GROUP      = 4;
    localparam int PRIO_W     = 4;

    localparam int NUM_GROUPS = NUM_LINES / GROUP;
    localparam int IDX_W      = $clog2(NUM_LINES);
    localparam int GRP_W      = $clog2(GROUP);
    localparam int CNT_W      = $clog2(NUM_GROUPS);

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [PRIO_W-1:0] prio;
    } cand_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SORT = 1'b1
    } sort_state_e;

    localparam cand_t CAND_NONE = '0;

    // a strictly beats b: valid over invalid, then higher priority, then lower index
    function automatic logic beats(cand_t a, cand_t b);
        if (!a.valid)           return 1'b0;
        if (!b.valid)           return 1'b1;
        if (a.prio != b.prio)   return a.prio > b.prio;
        return a.idx < b.idx;
    endfunction

    function automatic cand_t pick(cand_t a, cand_t b);
        return beats(b, a) ? b : a;
    endfunction

endpackage

// File: rtl/irq_mask_stage.sv
module irq_mask_stage
    import irq_sort_pkg::*;
(
    input  logic [NUM_LINES-1:0] req,
    input  logic [NUM_LINES-1:0] mask,
    output logic [NUM_LINES-1:0] active,
    output logic                 any_active
);
    always_comb begin
        active     = req & ~mask;
        any_active = |active;
    end
endmodule

// File: rtl/irq_group_cmp.sv
module irq_group_cmp
    import irq_sort_pkg::*;
(
    input  cand_t cand [GROUP],
    input  cand_t stored,
    output cand_t result
);
    // linear fold; order-independent because beats() breaks ties by index
    always_comb begin
        cand_t acc;
        acc = stored;
        for (int j = 0; j < GROUP; j++) begin
            acc = pick(acc, cand[j]);
        end
        result = acc;
    end
endmodule

// File: rtl/irq_sort_ctrl.sv
module irq_sort_ctrl
    import irq_sort_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             any_active,
    output logic             start,
    output logic             sort_en,
    output logic             last_step,
    output logic [CNT_W-1:0] grp
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_GROUPS - 1);

    sort_state_e      state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (any_active) state <= ST_SORT;
                end
                ST_SORT: begin
                    if (cnt == CNT_LAST) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        start     = (state == ST_IDLE) && any_active;
        sort_en   = (state == ST_SORT);
        last_step = sort_en && (cnt == CNT_LAST);
        grp       = cnt;
    end

    // R3: an idle block with an active line enters the first group
    assert_sort_begins_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && any_active) |=> (state == ST_SORT && cnt == '0));

    // R3: mid-sort the counter advances by one each cycle
    assert_cnt_steps_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SORT && cnt != CNT_LAST) |=>
            (state == ST_SORT && cnt == CNT_W'($past(cnt) + 1'b1)));

    // R8: after the last group the controller is idle again
    assert_back_to_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SORT && cnt == CNT_LAST) |=> (state == ST_IDLE));
endmodule

// File: rtl/irq_group_sorter.sv
module irq_group_sorter
    import irq_sort_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_LINES-1:0]        irq_req,
    input  logic [NUM_LINES-1:0]        irq_mask,
    input  logic [NUM_LINES*PRIO_W-1:0] irq_prio,
    output logic [IDX_W-1:0]            win_idx,
    output logic                        win_valid,
    output logic                        sort_done
);
    logic [NUM_LINES-1:0] active;
    logic                 any_active;
    logic                 start, sort_en, last_step;
    logic [CNT_W-1:0]     grp;
    cand_t                cand [GROUP];
    cand_t                stored_q;
    cand_t                result;

    irq_mask_stage u_mask (
        .req        (irq_req),
        .mask       (irq_mask),
        .active     (active),
        .any_active (any_active)
    );

    irq_sort_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .any_active (any_active),
        .start      (start),
        .sort_en    (sort_en),
        .last_step  (last_step),
        .grp        (grp)
    );

    // candidates of the current group: line = grp*GROUP + j
    for (genvar j = 0; j < GROUP; j++) begin : g_cand
        logic [IDX_W-1:0] line;
        always_comb begin
            line          = {grp, GRP_W'(j)};
            cand[j].valid = active[line];
            cand[j].idx   = line;
            cand[j].prio  = irq_prio[line*PRIO_W +: PRIO_W];
        end

        // R5/R6: the comparator never drops a stronger candidate of the group
        assert_group_not_beaten_R5: assert property (@(posedge clk) disable iff (rst)
            sort_en |-> !beats(cand[j], result));
    end

    irq_group_cmp u_cmp (
        .cand   (cand),
        .stored (stored_q),
        .result (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q <= CAND_NONE;
        end else if (start) begin
            stored_q <= CAND_NONE;
        end else if (sort_en) begin
            stored_q <= result;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_idx   <= '0;
            win_valid <= 1'b0;
            sort_done <= 1'b0;
        end else begin
            sort_done <= last_step;
            if (last_step) begin
                win_idx   <= result.idx;
                win_valid <= result.valid;
            end
        end
    end

    // R6: the carried winner is only replaced by a stronger candidate
    assert_stored_not_beaten_R6: assert property (@(posedge clk) disable iff (rst)
        sort_en |-> !beats(stored_q, result));

    // R2: a valid running winner is always a requesting, unmasked line
    assert_winner_unmasked_R2: assert property (@(posedge clk) disable iff (rst)
        (sort_en && result.valid) |-> (irq_req[result.idx] && !irq_mask[result.idx]));

    // R9: the running winner is empty while the first group is compared
    assert_fresh_start_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> !stored_q.valid);

    // R3: the completion pulse lasts one cycle
    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        sort_done |=> !sort_done);

    // R7: outputs hold except at the loading edge
    assert_win_holds_R7: assert property (@(posedge clk) disable iff (rst)
        !last_step |=> ($stable(win_idx) && $stable(win_valid)));

    // R1: reset leaves the outputs cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!sort_done && !win_valid && win_idx == '0));

    logic unused_prio;
    assign unused_prio = ^result.prio;
endmodule

// File: tb/test_irq_group_sorter.sv
module test_irq_group_sorter;
    import irq_sort_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int SORT_LAT   = NUM_GROUPS + 1;
    localparam int WATCHDOG   = 50000;

    typedef struct {
        int                 due;
        logic [IDX_W-1:0]   idx;
        logic               valid;
        string              tag;
    } exp_t;

    logic                        clk = 1'b0;
    logic                        rst = 1'b1;
    logic [NUM_LINES-1:0]        irq_req  = '0;
    logic [NUM_LINES-1:0]        irq_mask = '0;
    logic [NUM_LINES*PRIO_W-1:0] irq_prio = '0;
    logic [IDX_W-1:0]            win_idx;
    logic                        win_valid;
    logic                        sort_done;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   cyc      = 0;
    exp_t sb [$];
    logic [31:0] lfsr = 32'hACE1_1234;

    irq_group_sorter i_irq_group_sorter (
        .clk       (clk),
        .rst       (rst),
        .irq_req   (irq_req),
        .irq_mask  (irq_mask),
        .irq_prio  (irq_prio),
        .win_idx   (win_idx),
        .win_valid (win_valid),
        .sort_done (sort_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic ok, input string req_tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // monitor: pops expected results as completion pulses appear
    always @(negedge clk) begin
        if (!rst && sort_done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3", "unexpected sort_done", cyc, -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(cyc == e.due, "R3", {"done cycle ", e.tag}, cyc, e.due);
                check(win_valid == e.valid, e.tag, "win_valid", int'(win_valid), int'(e.valid));
                check(win_idx == e.idx, e.tag, "win_idx", int'(win_idx), int'(e.idx));
            end
        end
    end

    // watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "R3", "watchdog expired", cyc, WATCHDOG);
        finish_run();
    end

    function automatic exp_t model(input logic [NUM_LINES-1:0] r,
                                   input logic [NUM_LINES-1:0] m,
                                   input logic [NUM_LINES*PRIO_W-1:0] p);
        exp_t e;
        int   best;
        best    = -1;
        e.idx   = '0;
        e.valid = 1'b0;
        for (int n = 0; n < NUM_LINES; n++) begin
            if (r[n] && !m[n] && int'(p[n*PRIO_W +: PRIO_W]) > best) begin
                best    = int'(p[n*PRIO_W +: PRIO_W]);
                e.idx   = IDX_W'(n);
                e.valid = 1'b1;
            end
        end
        return e;
    endfunction

    // driver: apply at a falling edge, queue results for each sort held
    task automatic run_sort(input logic [NUM_LINES-1:0] r,
                            input logic [NUM_LINES-1:0] m,
                            input logic [NUM_LINES*PRIO_W-1:0] p,
                            input int sorts, input string tag);
        exp_t e;
        int   t0;
        irq_req  = r;
        irq_mask = m;
        irq_prio = p;
        t0 = cyc;
        e  = model(r, m, p);
        e.tag = tag;
        for (int s = 1; s <= sorts; s++) begin
            e.due = t0 + s * SORT_LAT;
            sb.push_back(e);
        end
        repeat (sorts * SORT_LAT) @(negedge clk);
        irq_req = '0;
        repeat (2) @(negedge clk);
        check(sb.size() == 0, tag, "pending results", sb.size(), 0);
    endtask

    function automatic logic [NUM_LINES*PRIO_W-1:0] set_prio(
            input logic [NUM_LINES*PRIO_W-1:0] p, input int n, input int v);
        p[n*PRIO_W +: PRIO_W] = PRIO_W'(v);
        return p;
    endfunction

    initial begin
        logic [NUM_LINES*PRIO_W-1:0] p;
        logic [IDX_W-1:0]            hold_idx;
        logic                        hold_valid;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!sort_done && !win_valid && win_idx == '0, "R1", "outputs in reset",
              int'({win_idx, win_valid, sort_done}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!sort_done && !win_valid && win_idx == '0, "R1", "outputs after reset",
              int'({win_idx, win_valid, sort_done}), 0);

        // R9: lone priority-0 request in the last group
        run_sort(32'h8000_0000, '0, '0, 1, "R9");

        // R4: distinct priorities
        p = '0;
        p = set_prio(p, 2, 3); p = set_prio(p, 13, 11); p = set_prio(p, 22, 6); p = set_prio(p, 30, 9);
        run_sort(32'h4040_2004, '0, p, 1, "R4");

        // R5: tie inside one group, lines 9 and 10
        p = '0;
        p = set_prio(p, 9, 7); p = set_prio(p, 10, 7); p = set_prio(p, 11, 2);
        run_sort(32'h0000_0E00, '0, p, 1, "R5");

        // R6: tie across groups, lines 3 and 28
        p = '0;
        p = set_prio(p, 3, 12); p = set_prio(p, 28, 12); p = set_prio(p, 17, 4);
        run_sort(32'h1002_0008, '0, p, 1, "R6");

        // R2: strongest line masked
        p = '0;
        p = set_prio(p, 20, 15); p = set_prio(p, 5, 9); p = set_prio(p, 6, 1);
        run_sort(32'h0010_0060, 32'h0010_0000, p, 1, "R2");

        // R2 / R7: only masked requests -> no sort, outputs hold
        hold_idx   = win_idx;
        hold_valid = win_valid;
        irq_req  = 32'hFFFF_0000;
        irq_mask = 32'hFFFF_0000;
        repeat (20) @(negedge clk);
        check(win_idx == hold_idx && win_valid == hold_valid, "R2", "masked-only idle",
              int'(win_idx), int'(hold_idx));
        irq_req  = '0;
        irq_mask = '0;
        @(negedge clk);

        // R8: requests held over two sorts
        p = '0;
        p = set_prio(p, 14, 8); p = set_prio(p, 25, 13);
        run_sort(32'h0200_4000, '0, p, 2, "R8");

        // R4: pseudo-random patterns
        for (int k = 0; k < 12; k++) begin
            logic [NUM_LINES-1:0] r, m;
            p = '0;
            for (int w = 0; w < (NUM_LINES*PRIO_W)/32; w++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                lfsr = lfsr * 32'd1664525 + 32'd1013904223;
                p[w*32 +: 32] = lfsr;
            end
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            r = lfsr;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            m = lfsr & lfsr[15:0] * 32'h0001_0001;
            if ((r & ~m) == '0) r[k] = 1'b1;
            if ((r & ~m) == '0) m[k] = 1'b0;
            run_sort(r, m, p, 1, "R4");
        end

        finish_run();
    end
endmodule